// File: doc/BRIEF.md
# Filtered Message Trace Recorder

This block watches the message stream of an on-chip message network and copies selected messages into a trace region of memory. Every observed message carries a 12-bit source station id, a 12-bit destination station id and a payload. Two independent filters can restrict capture: one to a single source id and one to a single destination id. With both filters off, every message is kept. The region runs from a programmed base address to a programmed limit address, both inclusive. Addresses count whole records.

Each kept message becomes one record, written through a valid/ready memory write port at the current write pointer. The pointer then moves on by one record. When the limit record has been written, the block either returns to the base (circular mode) or halts and raises a full flag (stop mode). The observed stream is never stalled. If a write is still waiting on the memory, a further kept message is discarded and counted.

Top module: `msg_trace_rec`

## Requirements
- R1: After a synchronous active-low reset, `mw_valid`, `wr_ptr`, `full` and `drop_cnt` are all zero.
- R2: While the enable bit (control bit 0) is clear, no observed message produces a write, and `wr_ptr` does not move.
- R3: A message is recorded only if each enabled filter matches exactly. The source filter is enabled by control bit 23 and compares against control bits 19..8. The destination filter is enabled by control bit 39 and compares against control bits 35..24. With both enables clear, every message is recorded.
- R4: A recorded message sampled at a clock edge shows `mw_valid`=1 after that edge. At the same point, `mw_addr` holds the write pointer the message found, and `mw_data` is {source id, destination id, payload}, with the source id in the top bits. If that pointer was below the limit, it then advances by one.
- R5: When the record written is at the limit address and the wrap bit (control bit 1) is set, the write pointer returns to the base address.
- R6: When the record written is at the limit address and the wrap bit is clear, `full` is set, `wr_ptr` stays at the limit, and later messages are not recorded.
- R7: A control write that changes the enable bit from 0 to 1 reloads `wr_ptr` with the base address and clears `full` and `drop_cnt`. A control write made while enable is already 1 leaves `wr_ptr` unchanged.
- R8: While `mw_valid` is high and `mw_ready` is low, the pending address and data hold steady. A further message that would be recorded is discarded instead: `drop_cnt` increments (saturating) and `wr_ptr` does not move.
- R9: `cfg_sel` selects the register that a `cfg_we` write updates: 0 is the base address, 1 is the limit address and 2 is the control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 base, 1 limit, 2 control |
| cfg_wdata | input | 40 | Configuration write data |
| obs_valid | input | 1 | Observed message present |
| obs_src | input | 12 | Observed source station id |
| obs_dst | input | 12 | Observed destination station id |
| obs_payload | input | PAY_W | Observed payload |
| mw_valid | output | 1 | Memory write request |
| mw_ready | input | 1 | Memory accepts the write |
| mw_addr | output | ADDR_W | Record address of the write |
| mw_data | output | 24+PAY_W | Record {src, dst, payload} |
| wr_ptr | output | ADDR_W | Next record address |
| full | output | 1 | Stop-mode region exhausted |
| drop_cnt | output | DROP_W | Records discarded under backpressure |

## Verification
A corrupted write pointer appears at `mw_addr` on the very next recorded message, and in `wr_ptr` one cycle after any capture. Because of that, every capture is compared against a pointer model kept in the bench. A wrong filter decision shows at once as an extra or a missing `mw_valid` in the cycle after the message. A lost full or drop state shows when the next message is recorded, or is not counted, in stop mode or under a stall.

// File: rtl/trace_rec_pkg.sv
// Package: shared control-word layout and decoded control type for the
// trace recorder. Assumes a 40-bit control word and 12-bit station ids.
package trace_rec_pkg;
    localparam int ID_W  = 12;
    localparam int CFG_W = 40;

    localparam int BIT_EN     = 0;
    localparam int BIT_WRAP   = 1;
    localparam int SRC_LSB    = 8;
    localparam int BIT_SRC_EN = 23;
    localparam int DST_LSB    = 24;
    localparam int BIT_DST_EN = 39;

    typedef struct packed {
        logic            en;
        logic            wrap;
        logic            src_en;
        logic [ID_W-1:0] src_id;
        logic            dst_en;
        logic [ID_W-1:0] dst_id;
    } trace_ctrl_t;

    // Unpack a raw control word into its fields.
    function automatic trace_ctrl_t unpack_ctrl(input logic [CFG_W-1:0] w);
        trace_ctrl_t c;
        c.en     = w[BIT_EN];
        c.wrap   = w[BIT_WRAP];
        c.src_en = w[BIT_SRC_EN];
        c.src_id = w[SRC_LSB +: ID_W];
        c.dst_en = w[BIT_DST_EN];
        c.dst_id = w[DST_LSB +: ID_W];
        return c;
    endfunction
endpackage

// File: rtl/trace_match.sv
// Module: decides whether the observed message qualifies for recording.
// Assumes the control fields are stable registers; the result is purely
// combinational.
module trace_match
    import trace_rec_pkg::*;
(
    input  trace_ctrl_t     ctrl,
    input  logic            obs_valid,
    input  logic [ID_W-1:0] obs_src,
    input  logic [ID_W-1:0] obs_dst,
    output logic            hit
);
    logic src_ok;
    logic dst_ok;

    // Each filter passes when it is disabled or when its id matches.
    always_comb begin
        src_ok = !ctrl.src_en || (obs_src == ctrl.src_id);
        dst_ok = !ctrl.dst_en || (obs_dst == ctrl.dst_id);
        hit    = obs_valid && ctrl.en && src_ok && dst_ok;
    end
endmodule

// File: rtl/trace_ptr.sv
// Module: record write pointer with wrap-or-stop handling at the limit.
// Assumes base <= limit; addresses count records, not bytes.
module trace_ptr #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reload,
    input  logic              adv,
    input  logic              wrap,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] limit,
    output logic [ADDR_W-1:0] ptr,
    output logic              full
);
    logic at_limit;

    always_comb at_limit = (ptr == limit);

    // Pointer and full flag: reload on enable, step, wrap or halt at limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr  <= '0;
            full <= 1'b0;
        end else if (reload) begin
            ptr  <= base;
            full <= 1'b0;
        end else if (adv) begin
            if (!at_limit)  ptr  <= ptr + 1'b1;
            else if (wrap)  ptr  <= base;
            else            full <= 1'b1;
        end
    end

    a_r6_full_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !reload) |=> $stable(ptr));
    a_r4_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !at_limit && !reload) |=> (ptr == $past(ptr) + 1'b1));
    a_r5_wrap_to_base: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && at_limit && wrap && !reload) |=> (ptr == $past(base)));
    a_r6_stop_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && at_limit && !wrap && !reload) |=> full);
endmodule

// File: rtl/trace_wr_stage.sv
// Module: single-entry memory write register with valid/ready output and
// a saturating drop counter. Never stalls the caller: offers that arrive
// while a write is stuck are counted and discarded.
module trace_wr_stage #(
    parameter int ADDR_W = 16,
    parameter int REC_W  = 40,
    parameter int DROP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              offer,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [REC_W-1:0]  data_in,
    input  logic              mw_ready,
    output logic              mw_valid,
    output logic [ADDR_W-1:0] mw_addr,
    output logic [REC_W-1:0]  mw_data,
    output logic              accept,
    output logic [DROP_W-1:0] drop_cnt
);
    logic stalled;

    // Accept when the slot is empty or is being emptied this cycle.
    always_comb begin
        stalled = mw_valid && !mw_ready;
        accept  = offer && !stalled;
    end

    // Pending write register: load on accept, release on ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mw_valid <= 1'b0;
            mw_addr  <= '0;
            mw_data  <= '0;
        end else if (accept) begin
            mw_valid <= 1'b1;
            mw_addr  <= addr_in;
            mw_data  <= data_in;
        end else if (mw_ready) begin
            mw_valid <= 1'b0;
        end
    end

    // Saturating count of offers lost to backpressure.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)                       drop_cnt <= '0;
        else if (offer && stalled && !(&drop_cnt)) drop_cnt <= drop_cnt + 1'b1;
    end

    a_r8_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (mw_valid && !mw_ready) |=> (mw_valid && $stable(mw_addr) && $stable(mw_data)));
    a_r8_drop_only_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (!stalled && !clr) |=> $stable(drop_cnt));
endmodule

// File: rtl/msg_trace_rec.sv
// Module: top of the filtered message trace recorder. Holds the base,
// limit and control registers, filters observed messages and sends each
// kept message as one record to the memory write port.
// Assumes the observed stream cannot be stalled and base <= limit.
module msg_trace_rec
    import trace_rec_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int PAY_W  = 16,
    parameter int DROP_W = 8,
    localparam int REC_W = 2*ID_W + PAY_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              obs_valid,
    input  logic [ID_W-1:0]   obs_src,
    input  logic [ID_W-1:0]   obs_dst,
    input  logic [PAY_W-1:0]  obs_payload,
    output logic              mw_valid,
    input  logic              mw_ready,
    output logic [ADDR_W-1:0] mw_addr,
    output logic [REC_W-1:0]  mw_data,
    output logic [ADDR_W-1:0] wr_ptr,
    output logic              full,
    output logic [DROP_W-1:0] drop_cnt
);
    localparam logic [1:0] SEL_BASE  = 2'd0;
    localparam logic [1:0] SEL_LIMIT = 2'd1;
    localparam logic [1:0] SEL_CTRL  = 2'd2;

    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] limit_q;
    trace_ctrl_t       ctrl_q;
    trace_ctrl_t       ctrl_new;
    logic              reload;
    logic              hit;
    logic              offer;
    logic              accept;

    // Decode an incoming control word and detect an enable rising edge.
    always_comb begin
        ctrl_new = unpack_ctrl(cfg_wdata);
        reload   = cfg_we && (cfg_sel == SEL_CTRL) && ctrl_new.en && !ctrl_q.en;
    end

    // Configuration registers written through the select port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            limit_q <= '0;
            ctrl_q  <= '0;
        end else if (cfg_we) begin
            case (cfg_sel)
                SEL_BASE:  base_q  <= cfg_wdata[ADDR_W-1:0];
                SEL_LIMIT: limit_q <= cfg_wdata[ADDR_W-1:0];
                SEL_CTRL:  ctrl_q  <= ctrl_new;
                default:   ;
            endcase
        end
    end

    trace_match u_match (
        .ctrl      (ctrl_q),
        .obs_valid (obs_valid),
        .obs_src   (obs_src),
        .obs_dst   (obs_dst),
        .hit       (hit)
    );

    // A matching message is offered unless the stop-mode region is full.
    always_comb offer = hit && !full;

    trace_ptr #(.ADDR_W(ADDR_W)) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .reload (reload),
        .adv    (accept),
        .wrap   (ctrl_q.wrap),
        .base   (base_q),
        .limit  (limit_q),
        .ptr    (wr_ptr),
        .full   (full)
    );

    trace_wr_stage #(.ADDR_W(ADDR_W), .REC_W(REC_W), .DROP_W(DROP_W)) u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (reload),
        .offer    (offer),
        .addr_in  (wr_ptr),
        .data_in  ({obs_src, obs_dst, obs_payload}),
        .mw_ready (mw_ready),
        .mw_valid (mw_valid),
        .mw_addr  (mw_addr),
        .mw_data  (mw_data),
        .accept   (accept),
        .drop_cnt (drop_cnt)
    );

    a_r2_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q.en |-> !accept);
    a_r6_no_capture_full: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !accept);
    a_r7_reload_base: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (wr_ptr == $past(base_q) && !full));
endmodule

// File: tb/tb_msg_trace_rec.sv
module tb_msg_trace_rec;
    localparam int ADDR_W = 16;
    localparam int PAY_W  = 16;
    localparam int DROP_W = 8;
    localparam int REC_W  = 24 + PAY_W;
    localparam logic [15:0] BASE  = 16'h0040;
    localparam logic [15:0] LIMIT = 16'h0043;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_sel = '0;
    logic [39:0] cfg_wdata = '0;
    logic obs_valid = 1'b0;
    logic [11:0] obs_src = '0, obs_dst = '0;
    logic [PAY_W-1:0] obs_payload = '0;
    logic mw_valid, mw_ready;
    logic [ADDR_W-1:0] mw_addr, wr_ptr;
    logic [REC_W-1:0] mw_data;
    logic full;
    logic [DROP_W-1:0] drop_cnt;
    int n_chk = 0, n_bad = 0;
    logic [15:0] mptr;

    always #4 clk = ~clk;

    msg_trace_rec #(.ADDR_W(ADDR_W), .PAY_W(PAY_W), .DROP_W(DROP_W)) dut (.*);

    // vector: {src_en, src_id, dst_en, dst_id, msg_src, msg_dst, expect_record}
    localparam int NV = 9;
    localparam logic [50:0] VEC [NV] = '{
        {1'b0, 12'h000, 1'b0, 12'h000, 12'h123, 12'h456, 1'b1},
        {1'b1, 12'h123, 1'b0, 12'h000, 12'h123, 12'h007, 1'b1},
        {1'b1, 12'h123, 1'b0, 12'h000, 12'h124, 12'h007, 1'b0},
        {1'b0, 12'h000, 1'b1, 12'hABC, 12'h001, 12'hABC, 1'b1},
        {1'b0, 12'h000, 1'b1, 12'hABC, 12'h001, 12'hABD, 1'b0},
        {1'b1, 12'h0F0, 1'b1, 12'h00F, 12'h0F0, 12'h00F, 1'b1},
        {1'b1, 12'h0F0, 1'b1, 12'h00F, 12'h0F0, 12'h00E, 1'b0},
        {1'b1, 12'h0F0, 1'b1, 12'h00F, 12'h0F1, 12'h00F, 1'b0},
        {1'b0, 12'h000, 1'b0, 12'h000, 12'hFFF, 12'h000, 1'b1}
    };

    function automatic logic [39:0] ctrl_word(input logic en, input logic wrap,
        input logic sen, input logic [11:0] sid, input logic den, input logic [11:0] did);
        return {den, 3'b000, did, sen, 3'b000, sid, 6'b000000, wrap, en};
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cfg(input logic [1:0] sel, input logic [39:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Present one message for one edge; return at the following negedge.
    task automatic send(input logic [11:0] s, input logic [11:0] d, input logic [15:0] p);
        @(negedge clk);
        obs_valid = 1'b1; obs_src = s; obs_dst = d; obs_payload = p;
        @(negedge clk);
        obs_valid = 1'b0;
    endtask

    function automatic logic [15:0] step(input logic [15:0] p);
        return (p == LIMIT) ? BASE : p + 16'd1;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        mw_ready = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(mw_valid == 0 && wr_ptr == 0 && full == 0 && drop_cnt == 0, "R1", {mw_valid, wr_ptr, full}, 0);
        rst_n = 1'b1;
        cfg(2'd0, 40'(BASE));   // R9: select 0 writes base
        cfg(2'd1, 40'(LIMIT));  // R9: select 1 writes limit
        cfg(2'd2, ctrl_word(1, 1, 0, 0, 0, 0));
        check(wr_ptr == BASE, "R7 R9 reload base", wr_ptr, BASE);
        mptr = BASE;

        // Table walk: R3 filters, R4 record format, R5 wrap, R7 no reload while enabled
        for (int i = 0; i < NV; i++) begin
            logic [50:0] v;
            logic [15:0] pay;
            v = VEC[i];
            pay = 16'hA000 + 16'(i);
            cfg(2'd2, ctrl_word(1, 1, v[50], v[49:38], v[37], v[36:25]));
            check(wr_ptr == mptr, "R7 rewrite keeps ptr", wr_ptr, mptr);
            send(v[24:13], v[12:1], pay);
            check(mw_valid == v[0], "R3 record decision", mw_valid, v[0]);
            if (v[0]) begin
                check(mw_addr == mptr, "R4 address", mw_addr, mptr);
                check(mw_data == {v[24:13], v[12:1], pay}, "R4 data", mw_data, {v[24:13], v[12:1], pay});
                mptr = step(mptr);
            end
            check(wr_ptr == mptr, "R4 R5 pointer", wr_ptr, mptr);
        end

        // R2: disabled, nothing recorded
        cfg(2'd2, ctrl_word(0, 1, 0, 0, 0, 0));
        send(12'h111, 12'h222, 16'h5555);
        check(mw_valid == 0, "R2 no write", mw_valid, 0);
        check(wr_ptr == mptr, "R2 ptr still", wr_ptr, mptr);

        // R6: stop mode fills region then halts
        cfg(2'd2, ctrl_word(1, 0, 0, 0, 0, 0));
        check(wr_ptr == BASE && full == 0, "R7 reload", wr_ptr, BASE);
        for (int k = 0; k < 4; k++) begin
            send(12'h010, 12'h020, 16'(k));
            check(mw_valid && mw_addr == BASE + 16'(k), "R6 fill addr", mw_addr, BASE + 16'(k));
        end
        check(full == 1 && wr_ptr == LIMIT, "R6 full at limit", {full, wr_ptr}, {1'b1, LIMIT});
        send(12'h010, 12'h020, 16'h0099);
        check(mw_valid == 0, "R6 halted", mw_valid, 0);
        check(wr_ptr == LIMIT, "R6 ptr frozen", wr_ptr, LIMIT);

        // R7: re-enable clears full
        cfg(2'd2, ctrl_word(0, 1, 0, 0, 0, 0));
        cfg(2'd2, ctrl_word(1, 1, 0, 0, 0, 0));
        check(full == 0 && wr_ptr == BASE, "R7 clear full", {full, wr_ptr}, {1'b0, BASE});

        // R8: backpressure
        mw_ready = 1'b0;
        send(12'h0AA, 12'h0BB, 16'h1111);
        check(mw_valid && mw_addr == BASE, "R8 pending", mw_addr, BASE);
        send(12'h0CC, 12'h0DD, 16'h2222);
        check(mw_valid && mw_addr == BASE && mw_data == {12'h0AA, 12'h0BB, 16'h1111}, "R8 held", mw_data, {12'h0AA, 12'h0BB, 16'h1111});
        check(drop_cnt == 1, "R8 drop count", drop_cnt, 1);
        check(wr_ptr == BASE + 16'd1, "R8 ptr not moved by drop", wr_ptr, BASE + 16'd1);
        @(negedge clk); mw_ready = 1'b1;
        @(negedge clk);
        check(mw_valid == 0, "R8 drained", mw_valid, 0);
        cfg(2'd2, ctrl_word(0, 1, 0, 0, 0, 0));
        cfg(2'd2, ctrl_word(1, 1, 0, 0, 0, 0));
        check(drop_cnt == 0, "R7 clear drops", drop_cnt, 0);

        // R1: reset mid-run
        send(12'h001, 12'h002, 16'h0003);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check(mw_valid == 0 && wr_ptr == 0 && full == 0 && drop_cnt == 0, "R1 rerun", {mw_valid, wr_ptr}, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule